// File: doc/BRIEF.md
# SPI Mode-3 Register Slave

This block lets an external SPI master read and write a small bank of 32-bit registers that configure and report on a position-acquisition and trigger engine. Each transfer is one frame of 40 bits: an 8-bit command, then a 32-bit data word. The master sends the most significant bit first. The serial clock idles high, and both sides sample on its rising edge.

All SPI pins are brought into the system clock domain through synchronizers. The frame engine runs entirely on the system clock. It assembles the command and the data word. For a read command, it streams the selected register back on MISO. For a write, it commits the data when chip select rises, provided the frame was exactly 40 clocks long.

The register bank holds five configuration words and two spare-I/O control words. It returns a fixed identity word, and it passes external status inputs through as read-only registers. A write-only action register turns its bits into one-cycle command pulses. Every accepted write to a writable register raises a one-cycle strobe for that register.

Top module: `spi_reg_slave`

## Requirements
- R1: Frames are 40 bits, MSB first, sampled on SCK rising edges while CS_N is low. A full write frame to registers 3 to 7 stores the data word, which then appears on the matching configuration output: 3 trig_period_o, 4 trig_count_o, 5 pulse_width_o, 6 half_period_o, 7 clk_edges_o.
- R2: Command bit 7 set means write and clear means read. Command bits 6:0 hold the register number.
- R3: Register 0 always reads 0xCAFEA51C. Writes to it change nothing and raise no strobe.
- R4: In a read frame, MISO carries the selected register MSB first. Bit 31 is driven from the SCK falling edge after the eighth rising edge. Each later falling edge advances one bit.
- R5: A write takes effect only when CS_N rises after exactly 40 SCK rising edges. Frames of any other length leave every register unchanged.
- R6: An accepted write to register n raises wr_stb_o[n] for one system cycle. That cycle is the same one in which the new value first appears. Only registers 3 to 7, 9, 10 and 11 strobe.
- R7: Writing register 9 gives a one-cycle pulse on act_pos_o for data bit 0, act_start_o for bit 1, and act_trig_o for bit 2. Register 9 reads as zero.
- R8: A write to register 10 drives data bits 7:0 to io_next_val_o and bits 15:8 to io_next_dir_o (1 = output). Register 11 does the same for io_val_o and io_dir_o. A read of register 10 returns io_snap_i in bits 7:0, and a read of register 11 returns io_live_i in bits 7:0. The upper bits read as zero.
- R9: Registers 1, 2 and 8 read cnt_i, pos_lo_i and pos_hi_i. Writes to them have no effect.
- R10: Register numbers 12 to 127 read as zero. Writes to them change no output and raise no strobe.
- R11: After reset, every configuration and I/O output, every strobe and pulse, and MISO are zero.
- R12: MISO is low while CS_N is high and in write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI clock, idles high |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from master |
| miso_o | output | 1 | SPI data to master |
| cnt_i | input | 32 | Acquisition counters, read at register 1 |
| pos_lo_i | input | 32 | Last position low word, read at register 2 |
| pos_hi_i | input | 32 | Last position high word, read at register 8 |
| io_snap_i | input | 8 | Spare I/O sampled at last trigger, register 10 |
| io_live_i | input | 8 | Spare I/O live value, register 11 |
| trig_period_o | output | 32 | Register 3 |
| trig_count_o | output | 32 | Register 4 |
| pulse_width_o | output | 32 | Register 5 |
| half_period_o | output | 32 | Register 6 |
| clk_edges_o | output | 32 | Register 7 |
| io_next_val_o | output | 8 | Spare I/O value applied after next trigger |
| io_next_dir_o | output | 8 | Spare I/O direction applied after next trigger |
| io_val_o | output | 8 | Spare I/O value, immediate |
| io_dir_o | output | 8 | Spare I/O direction, immediate |
| act_pos_o | output | 1 | Single-position request pulse |
| act_start_o | output | 1 | Acquisition start pulse |
| act_trig_o | output | 1 | Single-trigger pulse |
| wr_stb_o | output | 12 | One-hot write strobe per register |

## Verification
The bench sends frames of 16, 39 and 41 clocks. A design that counted loosely, or that committed on the 40th edge instead of on chip-select release, would change a register on those frames. It checks that MISO shows bit 31 on the first data bit. A design that loaded read data one edge late would return every word shifted by one bit. Writes go to the identity register, the read-only status registers and unmapped numbers. A faulty decode would raise a strobe or change an output there. Action writes with several bits set must give exactly one pulse per bit, so pulses that stretch or stick are caught.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = CMD_W - 1;
  localparam int unsigned NUM_REGS = 12;
  localparam int unsigned IO_W     = 8;
  localparam int unsigned ACT_W    = 3;

  localparam int unsigned A_ID       = 0;
  localparam int unsigned A_CNT      = 1;
  localparam int unsigned A_POS_LO   = 2;
  localparam int unsigned A_CFG_BASE = 3;
  localparam int unsigned CFG_N      = 5;
  localparam int unsigned A_POS_HI   = 8;
  localparam int unsigned A_ACT      = 9;
  localparam int unsigned A_IO_NEXT  = 10;
  localparam int unsigned A_IO_NOW   = 11;

  localparam logic [31:0] ID_VALUE = 32'hCAFE_A51C;

  function automatic bit reg_writable(input int unsigned a);
    return (a >= A_CFG_BASE && a < A_CFG_BASE + CFG_N) ||
           a == A_ACT || a == A_IO_NEXT || a == A_IO_NOW;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W  = CMD_W - 1,
  localparam int unsigned FRAME_W = CMD_W + DATA_W,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              miso_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              sck_d, cs_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic              tx_on;
  logic              rise, fall, cs_rise;

  assign rise    = sck_i & ~sck_d & ~cs_ni;
  assign fall    = ~sck_i & sck_d & ~cs_ni;
  assign cs_rise = cs_ni & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d     <= 1'b1;
      cs_d      <= 1'b1;
      bit_cnt   <= '0;
      cmd_q     <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      tx_on     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sck_d   <= sck_i;
      cs_d    <= cs_ni;
      wr_en_o <= 1'b0;
      if (cs_ni) begin
        bit_cnt <= '0;
        tx_on   <= 1'b0;
        // commit only full-length write frames
        if (cs_rise && bit_cnt == CNT_W'(FRAME_W) && cmd_q[CMD_W-1]) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= cmd_q[ADDR_W-1:0];
          wr_data_o <= rx_sr;
        end
      end else begin
        if (rise) begin
          rx_sr <= {rx_sr[DATA_W-2:0], mosi_i};
          if (bit_cnt <= CNT_W'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(CMD_W-1)) cmd_q <= {rx_sr[CMD_W-2:0], mosi_i};
        end
        if (fall) begin
          if (bit_cnt == CNT_W'(CMD_W)) begin
            tx_sr <= rd_data_i;
            tx_on <= ~cmd_q[CMD_W-1];
          end else if (bit_cnt > CNT_W'(CMD_W) && bit_cnt < CNT_W'(FRAME_W)) begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr_o = cmd_q[ADDR_W-1:0];
  assign miso_o    = tx_on & tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned NR  = NUM_REGS,
  parameter int unsigned IOW = IO_W,
  parameter int unsigned AXW = ACT_W,
  localparam int unsigned CN = CFG_N
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [DW-1:0]         rd_data_o,
  input  logic [DW-1:0]         cnt_i,
  input  logic [DW-1:0]         pos_lo_i,
  input  logic [DW-1:0]         pos_hi_i,
  input  logic [IOW-1:0]        io_snap_i,
  input  logic [IOW-1:0]        io_live_i,
  output logic [CN-1:0][DW-1:0] cfg_o,
  output logic [2*IOW-1:0]      io_next_o,
  output logic [2*IOW-1:0]      io_now_o,
  output logic [AXW-1:0]        act_o,
  output logic [NR-1:0]         wr_stb_o
);
  logic [NR-1:0] stb_d;

  for (genvar g = 0; g < NR; g++) begin : g_stb
    localparam bit WR_OK = reg_writable(g);
    assign stb_d[g] = WR_OK && wr_en_i && (wr_addr_i == AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      io_next_o <= '0;
      io_now_o  <= '0;
      act_o     <= '0;
      wr_stb_o  <= '0;
    end else begin
      wr_stb_o <= stb_d;
      act_o    <= stb_d[A_ACT] ? wr_data_i[AXW-1:0] : '0;
      for (int k = 0; k < CN; k++)
        if (stb_d[A_CFG_BASE+k]) cfg_o[k] <= wr_data_i;
      if (stb_d[A_IO_NEXT]) io_next_o <= wr_data_i[2*IOW-1:0];
      if (stb_d[A_IO_NOW])  io_now_o  <= wr_data_i[2*IOW-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(A_ID))     rd_data_o = DW'(ID_VALUE);
    if (rd_addr_i == AW'(A_CNT))    rd_data_o = cnt_i;
    if (rd_addr_i == AW'(A_POS_LO)) rd_data_o = pos_lo_i;
    if (rd_addr_i == AW'(A_POS_HI)) rd_data_o = pos_hi_i;
    if (rd_addr_i == AW'(A_IO_NEXT)) rd_data_o = DW'(io_snap_i);
    if (rd_addr_i == AW'(A_IO_NOW))  rd_data_o = DW'(io_live_i);
    for (int k = 0; k < CN; k++)
      if (rd_addr_i == AW'(A_CFG_BASE + k)) rd_data_o = cfg_o[k];
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic                mosi_i,
  output logic                miso_o,
  input  logic [DATA_W-1:0]   cnt_i,
  input  logic [DATA_W-1:0]   pos_lo_i,
  input  logic [DATA_W-1:0]   pos_hi_i,
  input  logic [IO_W-1:0]     io_snap_i,
  input  logic [IO_W-1:0]     io_live_i,
  output logic [DATA_W-1:0]   trig_period_o,
  output logic [DATA_W-1:0]   trig_count_o,
  output logic [DATA_W-1:0]   pulse_width_o,
  output logic [DATA_W-1:0]   half_period_o,
  output logic [DATA_W-1:0]   clk_edges_o,
  output logic [IO_W-1:0]     io_next_val_o,
  output logic [IO_W-1:0]     io_next_dir_o,
  output logic [IO_W-1:0]     io_val_o,
  output logic [IO_W-1:0]     io_dir_o,
  output logic                act_pos_o,
  output logic                act_start_o,
  output logic                act_trig_o,
  output logic [NUM_REGS-1:0] wr_stb_o
);
  logic [2:0]                 pins_s;
  logic                       wr_en;
  logic [ADDR_W-1:0]          wr_addr, rd_addr;
  logic [DATA_W-1:0]          wr_data, rd_data;
  logic [CFG_N-1:0][DATA_W-1:0] cfg;
  logic [2*IO_W-1:0]          io_next, io_now;
  logic [ACT_W-1:0]           act;

  // order: sck, cs_n, mosi; idle high on clock and select
  spi_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   (pins_s)
  );

  spi_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (pins_s[2]),
    .cs_ni    (pins_s[1]),
    .mosi_i   (pins_s[0]),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .miso_o   (miso_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  spi_reg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .cnt_i    (cnt_i),
    .pos_lo_i (pos_lo_i),
    .pos_hi_i (pos_hi_i),
    .io_snap_i(io_snap_i),
    .io_live_i(io_live_i),
    .cfg_o    (cfg),
    .io_next_o(io_next),
    .io_now_o (io_now),
    .act_o    (act),
    .wr_stb_o (wr_stb_o)
  );

  assign trig_period_o = cfg[0];
  assign trig_count_o  = cfg[1];
  assign pulse_width_o = cfg[2];
  assign half_period_o = cfg[3];
  assign clk_edges_o   = cfg[4];
  assign io_next_val_o = io_next[IO_W-1:0];
  assign io_next_dir_o = io_next[2*IO_W-1:IO_W];
  assign io_val_o      = io_now[IO_W-1:0];
  assign io_dir_o      = io_now[2*IO_W-1:IO_W];
  assign act_pos_o     = act[0];
  assign act_start_o   = act[1];
  assign act_trig_o    = act[2];
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                miso_o,
  input logic [DATA_W-1:0]   trig_period_o,
  input logic [IO_W-1:0]     io_val_o,
  input logic [IO_W-1:0]     io_dir_o,
  input logic                act_pos_o,
  input logic                act_start_o,
  input logic                act_trig_o,
  input logic [NUM_REGS-1:0] wr_stb_o
);
  logic any_act;
  assign any_act = act_pos_o | act_start_o | act_trig_o;

  // R7
  act_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act |=> !any_act);

  // R7
  act_needs_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act |-> wr_stb_o[A_ACT]);

  // R6
  stb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_stb_o));

  // R6
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o != '0) |=> (wr_stb_o == '0));

  // R1
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trig_period_o) |-> wr_stb_o[A_CFG_BASE]);

  // R8
  io_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({io_val_o, io_dir_o}) |-> wr_stb_o[A_IO_NOW]);

  // R9
  ro_no_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o[A_ID] | wr_stb_o[A_CNT] | wr_stb_o[A_POS_LO] | wr_stb_o[A_POS_HI]));

  // R12
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4))
      |-> !miso_o);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .miso_o       (miso_o),
  .trig_period_o(trig_period_o),
  .io_val_o     (io_val_o),
  .io_dir_o     (io_dir_o),
  .act_pos_o    (act_pos_o),
  .act_start_o  (act_start_o),
  .act_trig_o   (act_trig_o),
  .wr_stb_o     (wr_stb_o)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [31:0] cnt_v, pos_lo_v, pos_hi_v;
  logic [7:0] snap_v, live_v;
  logic [31:0] trig_period, trig_count, pulse_width, half_period, clk_edges;
  logic [7:0] nv, nd, cv, cd;
  logic a_pos, a_start, a_trig;
  logic [11:0] stb;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int pulses [3];
  int stb_cnt [12];
  int stb_total = 0;

  logic [31:0] exp_cfg [5];
  logic [15:0] exp_next, exp_now;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .cnt_i(cnt_v), .pos_lo_i(pos_lo_v), .pos_hi_i(pos_hi_v),
    .io_snap_i(snap_v), .io_live_i(live_v),
    .trig_period_o(trig_period), .trig_count_o(trig_count), .pulse_width_o(pulse_width),
    .half_period_o(half_period), .clk_edges_o(clk_edges),
    .io_next_val_o(nv), .io_next_dir_o(nd), .io_val_o(cv), .io_dir_o(cd),
    .act_pos_o(a_pos), .act_start_o(a_start), .act_trig_o(a_trig), .wr_stb_o(stb)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      pulses[0] <= pulses[0] + int'(a_pos);
      pulses[1] <= pulses[1] + int'(a_start);
      pulses[2] <= pulses[2] + int'(a_trig);
      stb_total <= stb_total + $countones(stb);
      for (int i = 0; i < 12; i++) stb_cnt[i] <= stb_cnt[i] + int'(stb[i]);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit writable(input int a);
    return (a >= 3 && a <= 7) || a == 9 || a == 10 || a == 11;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    if (a == 0) return 32'hCAFEA51C;
    if (a == 1) return cnt_v;
    if (a == 2) return pos_lo_v;
    if (a >= 3 && a <= 7) return exp_cfg[a-3];
    if (a == 8) return pos_hi_v;
    if (a == 10) return {24'h0, snap_v};
    if (a == 11) return {24'h0, live_v};
    return 32'h0;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a >= 3 && a <= 7) exp_cfg[a-3] = d;
    if (a == 10) exp_next = d[15:0];
    if (a == 11) exp_now = d[15:0];
  endtask

  task automatic check_outs(input string req);
    chk({req, " period"}, trig_period, exp_cfg[0]);
    chk({req, " count"},  trig_count,  exp_cfg[1]);
    chk({req, " width"},  pulse_width, exp_cfg[2]);
    chk({req, " half"},   half_period, exp_cfg[3]);
    chk({req, " edges"},  clk_edges,   exp_cfg[4]);
    chk({req, " io_next"}, {16'h0, nd, nv}, {16'h0, exp_next});
    chk({req, " io_now"},  {16'h0, cd, cv}, {16'h0, exp_now});
  endtask

  task automatic spi_xfer(input logic [7:0] cmd, input logic [31:0] data,
                          input int nbits, output logic [31:0] rd);
    logic [39:0] word;
    word = {cmd, data};
    rd = '0;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      mosi = (i < 40) ? word[39-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i >= 8 && i < 40) rd = {rd[30:0], miso};
      sck = 1'b1;
      repeat (HP) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (3*HP) @(negedge clk);
  endtask

  // full read with value check
  task automatic do_read(input int a, input string req);
    logic [31:0] rd;
    spi_xfer({1'b0, 7'(a)}, $urandom, 40, rd);
    chk(req, rd, model_read(a));
  endtask

  // full write with strobe and output check
  task automatic do_write(input int a, input logic [31:0] d, input string req);
    logic [31:0] rd;
    int t0, s0;
    int p0 [3];
    t0 = stb_total;
    s0 = (a < 12) ? stb_cnt[a] : 0;
    for (int k = 0; k < 3; k++) p0[k] = pulses[k];
    spi_xfer({1'b1, 7'(a)}, d, 40, rd);
    model_write(a, d);
    // R12 write frames keep MISO low
    chk("R12 write-frame miso", {31'h0, miso}, 32'h0);
    chk({req, " R6 strobes"}, 32'(stb_total - t0), writable(a) ? 32'd1 : 32'd0);
    if (writable(a)) chk({req, " R6 own strobe"}, 32'(stb_cnt[a] - s0), 32'd1);
    if (a == 9)
      for (int k = 0; k < 3; k++)
        chk("R7 pulse count", 32'(pulses[k] - p0[k]), {31'h0, d[k]});
    check_outs(req);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int a, nb;
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int k = 0; k < 3; k++) pulses[k] = 0;
    for (int i = 0; i < 12; i++) stb_cnt[i] = 0;
    for (int k = 0; k < 5; k++) exp_cfg[k] = '0;
    exp_next = '0;
    exp_now = '0;
    cnt_v = 32'h1234_5678; pos_lo_v = 32'h8000_0001; pos_hi_v = 32'h0000_00A5;
    snap_v = 8'h3C; live_v = 8'hC1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check_outs("R11 reset");
    chk("R11 reset miso", {31'h0, miso}, 32'h0);
    chk("R11 reset strobe", {20'h0, stb}, 32'h0);

    // R3 identity, R9 status, R8 io inputs
    do_read(0, "R3 id read");
    do_read(1, "R9 cnt read");
    do_read(2, "R9 pos_lo read");
    do_read(8, "R9 pos_hi read");
    do_read(10, "R8 snap read");
    do_read(11, "R8 live read");
    // R4 MSB on first data bit: pattern with only bit 31 set
    pos_lo_v = 32'h8000_0000;
    do_read(2, "R4 msb first");
    pos_lo_v = 32'h0000_0001;
    do_read(2, "R4 lsb last");

    // R1 R2 writes and readback
    do_write(3, 32'hDEAD_BEEF, "R1 write period");
    do_read(3, "R2 read period");
    do_write(7, 32'h0000_0027, "R1 write edges");
    do_read(7, "R2 read edges");
    do_write(0, 32'h1111_1111, "R3 write id");
    do_read(0, "R3 id after write");
    do_write(1, 32'h2222_2222, "R9 write cnt");
    do_write(12, 32'hFFFF_FFFF, "R10 write unmapped");
    do_write(127, 32'hFFFF_FFFF, "R10 write unmapped high");
    do_read(12, "R10 read unmapped");
    do_read(100, "R10 read unmapped high");
    do_write(10, 32'hFFFF_A55A, "R8 write next");
    do_write(11, 32'h0000_0F81, "R8 write now");
    do_write(9, 32'h0000_0007, "R7 all actions");
    do_write(9, 32'hFFFF_FFFA, "R7 action mix");
    do_read(9, "R7 action reads zero");

    // R5 wrong-length frames
    spi_xfer(8'h83, 32'h0BAD_0BAD, 39, rd);
    check_outs("R5 39-bit frame");
    spi_xfer(8'h83, 32'h0BAD_0BAD, 41, rd);
    check_outs("R5 41-bit frame");
    spi_xfer(8'h8B, 32'h0000_FFFF, 16, rd);
    check_outs("R5 16-bit frame");
    chk("R12 idle miso", {31'h0, miso}, 32'h0);

    // random mix
    for (int n = 0; n < 70; n++) begin
      a = ($urandom_range(0, 3) == 0) ? 9 : $urandom_range(0, 14);
      d = $urandom;
      nb = ($urandom_range(0, 7) == 0) ? (($urandom_range(0, 1) == 0) ? 39 : 41) : 40;
      if (nb != 40) begin
        spi_xfer({1'b1, 7'(a)}, d, nb, rd);
        check_outs("R5 random short/long");
      end else if ($urandom_range(0, 1) == 0) begin
        do_write(a, d, "R1 random write");
      end else begin
        do_read(a, "R2 random read");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule